// File: doc/BRIEF.md
# Interrupt Distributor Global Control Registers

This block holds the global control words of an interrupt distributor behind a 32-bit register port that covers a 12-byte window. A single register holds the distributor-wide enable. A read-only word reports the number of interrupt lines and how many processors are online, and it is built from live configuration inputs. A second read-only word returns a fixed identification value made of a product code and an implementer code.

When software turns the distributor on, which means the enable moves from off to on, the block raises a one-cycle `wake_pulse`. Other logic uses this pulse to prompt every processor to look again for pending work. Per-interrupt state, prioritisation, delivery, software-generated interrupts and routing belong to other blocks.

Top module: `irq_dist_ctrl_regs`

## Requirements
- R1: After reset, `dist_on` and `wake_pulse` are 0 and the control word reads 0.
- R2: Address bits [3:2] select the word: 0 is control, 1 is the type word, 2 is identification. Bits [1:0] are ignored. A write to control stores `wr_data[0]` as the enable, and the new value appears on `dist_on` and on read bit 0 from the cycle after the write. Control bits [31:1] read as 0.
- R3: Type word bits [4:0] read ((`shared_irqs` + 32) >> 5) − 1. `shared_irqs` is a multiple of 32.
- R4: Type word bits [7:5] read `cpus_online` − 1, and bits [31:8] read 0.
- R5: The identification word reads `PRODUCT_CODE` in bits [31:24] and `IMPL_CODE` in bits [11:0], with every other bit 0. The defaults are 0x4B and 0x43B, so the word reads 0x4B00043B.
- R6: A write to the type word, the identification word or select 3 leaves the enable unchanged and raises no pulse.
- R7: A control write that turns the enable from 0 to 1 raises `wake_pulse` for exactly one cycle. The pulse appears in the same cycle as the new enable.
- R8: Writing 1 to control while the enable is already 1 raises no pulse. Writing 0 to control raises no pulse.
- R9: Select 3 (offset 0xC) reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| addr | input | 4 | Byte offset within the window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| shared_irqs | input | 10 | Number of shared interrupts, a multiple of 32 |
| cpus_online | input | 4 | Number of online processors, 1 to 8 |
| dist_on | output | 1 | Global enable |
| wake_pulse | output | 1 | One-cycle pulse when the enable turns on |

## Verification
The bench writes 1 to control twice in a row. A design that fires on the level of the enable instead of its edge would pulse again on the second write. It also checks that the pulse drops after one cycle and does not fire on a write of 0. Writes that carry bit 0 set are sent to the type word, the identification word and offset 0xC. A decoder that ignored bits [3:2] would turn the distributor on through those writes. The type word is read across several interrupt and processor counts, including the largest line count and eight processors. An error in the subtraction or an off-by-one in the field position would show up in those reads.

// File: rtl/irq_dist_ctrl_regs.sv
module irq_dist_ctrl_regs #(
  parameter int ADDR_W       = 4,
  parameter int SHARED_W     = 10,
  parameter int CPU_W        = 4,
  parameter int CPU_FIELD_W  = 3,
  parameter logic [7:0]  PRODUCT_CODE = 8'h4B,
  parameter logic [11:0] IMPL_CODE    = 12'h43B
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wr_data,
  output logic [31:0]         rd_data,
  input  logic [SHARED_W-1:0] shared_irqs,
  input  logic [CPU_W-1:0]    cpus_online,
  output logic                dist_on,
  output logic                wake_pulse
);
  localparam int TOTAL_W   = SHARED_W + 1;
  localparam int LINES_W   = 5;
  localparam int TYPE_USED = LINES_W + CPU_FIELD_W;

  logic [1:0]         sel;
  logic [TOTAL_W-1:0] total_lines;
  logic [TOTAL_W-1:0] groups;
  logic [CPU_W-1:0]   cpus_m1;
  logic [31:0]        type_word;
  logic [31:0]        id_word;
  logic               ctrl_wr;

  assign sel         = addr[3:2];
  assign ctrl_wr     = wr_en && (sel == 2'd0);
  assign total_lines = TOTAL_W'(shared_irqs) + TOTAL_W'(32);
  assign groups      = (total_lines >> 5) - TOTAL_W'(1);
  assign cpus_m1     = cpus_online - CPU_W'(1);
  assign type_word   = {{(32-TYPE_USED){1'b0}}, cpus_m1[CPU_FIELD_W-1:0], groups[LINES_W-1:0]};
  assign id_word     = {PRODUCT_CODE, 12'd0, IMPL_CODE};

  always_comb begin
    case (sel)
      2'd0:    rd_data = {31'd0, dist_on};
      2'd1:    rd_data = type_word;
      2'd2:    rd_data = id_word;
      default: rd_data = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dist_on    <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= ctrl_wr && wr_data[0] && !dist_on;
      if (ctrl_wr) dist_on <= wr_data[0];
    end
  end
endmodule

module irq_dist_ctrl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  addr,
  input logic [31:0] wr_data,
  input logic        dist_on,
  input logic        wake_pulse
);
  assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[3:2] == 2'd0) |=> (dist_on == $past(wr_data[0])));
  assert_other_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[3:2] != 2'd0) |=> ($stable(dist_on) && !wake_pulse));
  assert_pulse_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dist_on) |-> wake_pulse);
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (dist_on && !$past(dist_on)));
endmodule

bind irq_dist_ctrl_regs irq_dist_ctrl_regs_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .dist_on(dist_on), .wake_pulse(wake_pulse));

// File: tb/test_irq_dist_ctrl_regs.sv
module test_irq_dist_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {shared_irqs, cpus_online, expected type word}
  localparam logic [45:0] TYPE_VEC [NVEC] = '{
    {10'd0,   4'd1, 32'h00000000},
    {10'd32,  4'd2, 32'h00000021},
    {10'd96,  4'd3, 32'h00000043},
    {10'd224, 4'd8, 32'h000000E7},
    {10'd992, 4'd4, 32'h0000007F}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [9:0] shared_irqs = '0;
  logic [3:0] cpus_online = 4'd1;
  logic dist_on, wake_pulse;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dist_ctrl_regs i_irq_dist_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .shared_irqs(shared_irqs), .cpus_online(cpus_online),
    .dist_on(dist_on), .wake_pulse(wake_pulse));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_word(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic write_word(input logic [3:0] a, input logic [31:0] d, output logic pulse);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    pulse = wake_pulse;
  endtask

  initial begin
    logic [31:0] r;
    logic p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 dist_on", {31'd0, dist_on}, 32'd0);
    check("R1 wake_pulse", {31'd0, wake_pulse}, 32'd0);
    read_word(4'h0, r); check("R1 control", r, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      shared_irqs = TYPE_VEC[i][45:36];
      cpus_online = TYPE_VEC[i][35:32];
      read_word(4'h4, r);
      check("R3/R4 type word", r, TYPE_VEC[i][31:0]);
    end
    read_word(4'h6, r); check("R2 low addr bits ignored", r, TYPE_VEC[NVEC-1][31:0]);

    read_word(4'h8, r); check("R5 identification", r, 32'h4B00043B);
    read_word(4'hC, r); check("R9 offset 0xC", r, 32'd0);

    write_word(4'h4, 32'hFFFFFFFF, p); check("R6 type write pulse", {31'd0, p}, 32'd0);
    write_word(4'h8, 32'hFFFFFFFF, p); check("R6 id write pulse", {31'd0, p}, 32'd0);
    write_word(4'hC, 32'hFFFFFFFF, p); check("R6 0xC write pulse", {31'd0, p}, 32'd0);
    check("R6 enable unchanged", {31'd0, dist_on}, 32'd0);
    read_word(4'h8, r); check("R6 id intact", r, 32'h4B00043B);

    write_word(4'h0, 32'hFFFFFFFF, p);
    check("R7 pulse on enable", {31'd0, p}, 32'd1);
    check("R2 dist_on set", {31'd0, dist_on}, 32'd1);
    read_word(4'h0, r);
    check("R7 pulse one cycle", {31'd0, wake_pulse}, 32'd0);
    check("R2 control readback", r, 32'd1);

    write_word(4'h0, 32'd1, p); check("R8 no pulse on rewrite", {31'd0, p}, 32'd0);
    write_word(4'hC, 32'd0, p); check("R6 enable kept", {31'd0, dist_on}, 32'd1);
    write_word(4'h0, 32'd0, p); check("R8 no pulse on disable", {31'd0, p}, 32'd0);
    check("R2 dist_on cleared", {31'd0, dist_on}, 32'd0);
    write_word(4'h3, 32'd1, p); check("R7 pulse again", {31'd0, p}, 32'd1);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 enable after reset", {31'd0, dist_on}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule